// File: doc/BRIEF.md
# Two-Wire Slave Front End with Address-Triggered Erase

This block is the bus-facing half of a small two-sector nonvolatile store. It watches the two-wire serial bus (clock and data, open-drain, so the data output is a drive-low enable) and decodes the 7-bit address byte that follows every start condition. If the address equals the configured device address, the block carries out a normal byte transfer. In write direction, each received byte goes out on a byte port. In read direction, bytes are fetched from the memory controller and shifted onto the bus.

A second bus address doubles as a whole-memory erase command. It shares the upper four bits with the device address and has all three low bits set. When that address arrives in write direction and write protect is low, the block acknowledges it and arms an erase. The erase itself starts only at the stop condition that closes the transfer. A one-clock start pulse goes to the memory controller, which clears both sectors and then returns a done pulse. Until then the block is busy and acknowledges no address, so a master finds out that the erase has finished by polling with address bytes.

Top module: `i2c_ers_slave`

## Requirements
- R1: A start is the synchronized data line falling while the synchronized clock is high, and a stop is it rising while the clock is high. A start at any point, including in the middle of a byte, restarts address decoding. Clock pulses that are not preceded by a start are ignored.
- R2: The address byte is received MSB first, with the direction bit last (1 = read). If the 7 address bits equal `dev_addr_i`, the block pulls data low through the whole ninth (acknowledge) clock.
- R3: In a write transfer, every received data byte is acknowledged. Each byte appears on `wr_data_o` together with a `wr_valid_o` pulse that lasts exactly one clock.
- R4: In a read transfer, at the start of each byte the block loads `rd_data_i` and pulses `rd_next_o` for one clock, then shifts the byte out MSB first. A master acknowledge (data low on the ninth clock) fetches another byte. A master no-acknowledge ends the transfer with no further fetch.
- R5: The erase address is `{dev_addr_i[6:3], 3'b111}`. With direction 0, write protect low and the block not busy, it is acknowledged. Data bytes that follow it are not acknowledged. `dev_addr_i[2:0]` must never be `3'b111`.
- R6: The erase address with direction 1 is not acknowledged and starts no erase.
- R7: While `wp_i` is 1, the erase address is not acknowledged and no erase starts.
- R8: `erase_start_o` pulses for one clock only after the stop condition that follows an acknowledged erase address, and never before that stop.
- R9: A repeated start, or an address that is not acknowledged, arriving after an acknowledged erase address and before the stop cancels the pending erase.
- R10: `busy_o` rises together with `erase_start_o` and falls the clock after `erase_done_i`. While it is high, no address (normal or erase) is acknowledged. Once it is low, addresses are acknowledged again.
- R11: An address that matches neither the device address nor the erase address is not acknowledged, and the bytes after it are ignored until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen on the pin |
| sda_i | input | 1 | Bus data line as seen on the pin |
| sda_oe_o | output | 1 | 1 pulls the data line low |
| dev_addr_i | input | 7 | Configured device address |
| wp_i | input | 1 | Write protect; blocks the erase command |
| erase_start_o | output | 1 | One-clock request to erase both sectors |
| erase_done_i | input | 1 | Controller reports the erase is complete |
| busy_o | output | 1 | Erase in progress; addresses are refused |
| wr_valid_o | output | 1 | One-clock strobe for a received byte |
| wr_data_o | output | 8 | Last received data byte |
| rd_next_o | output | 1 | One-clock strobe: `rd_data_i` was taken |
| rd_data_i | input | 8 | Byte to send for the next read slot |

## Verification
The bench checks that an acknowledged erase address does not trigger an erase before the stop. A design that fires on the address acknowledge would erase during the transfer, and a design that forgets the armed state at stop would never erase. It sends a repeated start, and separately an unknown address, between the erase address and the stop. Logic that ignores these would still erase. It polls during the busy window with both the normal address and the erase address. A design that ignores busy would acknowledge either one, and one that never clears busy after done would lock out the device address for good. It also sends the erase address with write protect set and with read direction, inserts a repeated start in the middle of a byte, and clocks bytes with no start at all. Each of these exposes decoding that does not gate on the direction bit, on protect, or on a prior start.

// File: rtl/i2c_ers_pkg.sv
package i2c_ers_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK,
    ST_HOLD
  } bus_st_e;

  typedef enum logic [1:0] {
    K_WR,
    K_RD,
    K_ERASE
  } xfer_e;

endpackage

// File: rtl/i2c_ers_line_sync.sv
module i2c_ers_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  localparam int NLINES = 2;

  logic [NLINES-1:0] lines_in;
  logic [NLINES-1:0] lines_s;
  logic [NLINES-1:0] lines_d;

  assign lines_in = {scl_i, sda_i};

  // one synchronizer chain per bus line; idle level of both lines is high
  for (genvar g = 0; g < NLINES; g++) begin : g_line
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain_q <= '1;
      end else begin
        chain_q <= {chain_q[STAGES-2:0], lines_in[g]};
      end
    end
    assign lines_s[g] = chain_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lines_d <= '1;
    end else begin
      lines_d <= lines_s;
    end
  end

  logic scl_now, scl_was, sda_was;
  assign scl_now   = lines_s[1];
  assign scl_was   = lines_d[1];
  assign sda_s     = lines_s[0];
  assign sda_was   = lines_d[0];

  assign scl_rise  = scl_now & ~scl_was;
  assign scl_fall  = ~scl_now & scl_was;
  assign start_det = scl_now & scl_was & sda_was & ~sda_s;
  assign stop_det  = scl_now & scl_was & ~sda_was & sda_s;

endmodule

// File: rtl/i2c_ers_addr_match.sv
module i2c_ers_addr_match #(
  parameter int AW = 7,
  parameter int EB = 3,
  parameter int DW = AW + 1
) (
  input  logic [DW-1:0] rx_byte,
  input  logic [AW-1:0] dev_addr,
  input  logic          wp,
  input  logic          busy,
  output logic          hit_erase,
  output logic          ack_ok
);

  logic [AW-1:0] rx_addr;
  logic          rx_read;
  logic          hit_norm;

  assign rx_addr   = rx_byte[DW-1 -: AW];
  assign rx_read   = rx_byte[0];
  assign hit_norm  = (rx_addr == dev_addr);
  assign hit_erase = (rx_addr[AW-1:EB] == dev_addr[AW-1:EB]) &&
                     (&rx_addr[EB-1:0]) && !rx_read;
  assign ack_ok    = !busy && (hit_norm || (hit_erase && !wp));

endmodule

// File: rtl/i2c_ers_erase_ctrl.sv
module i2c_ers_erase_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_set,
  input  logic arm_clr,
  input  logic stop_det,
  input  logic erase_done_i,
  output logic erase_start_o,
  output logic busy_o
);

  logic armed_q, armed_n;
  logic start_n, busy_n;

  always_comb begin
    armed_n = armed_q;
    start_n = 1'b0;
    busy_n  = busy_o;
    if (arm_clr) armed_n = 1'b0;
    if (arm_set) armed_n = 1'b1;
    if (stop_det) begin
      start_n = armed_q;
      armed_n = 1'b0;
    end
    if (start_n) begin
      busy_n = 1'b1;
    end else if (erase_done_i) begin
      busy_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q       <= 1'b0;
      erase_start_o <= 1'b0;
      busy_o        <= 1'b0;
    end else begin
      armed_q       <= armed_n;
      erase_start_o <= start_n;
      busy_o        <= busy_n;
    end
  end

  // R10: a new erase never starts on top of one still running
  p_no_restart_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start_o |-> !$past(busy_o));

endmodule

// File: rtl/i2c_ers_bus_fsm.sv
module i2c_ers_bus_fsm
  import i2c_ers_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sda_s,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic          ack_ok,
  input  logic          hit_erase,
  input  logic [DW-1:0] rd_data_i,
  output logic [DW-1:0] rx_byte,
  output logic          sda_oe_o,
  output logic          wr_valid_o,
  output logic [DW-1:0] wr_data_o,
  output logic          rd_next_o,
  output logic          arm_set,
  output logic          arm_clr,
  output logic          addr_ack,
  output logic          ack_erase
);

  localparam int CW = $clog2(DW + 1);

  bus_st_e        st_q, st_n;
  xfer_e          kind_q, kind_n;
  logic [CW-1:0]  cnt_q, cnt_n;
  logic [DW-1:0]  sh_q, sh_n;
  logic [DW-1:0]  wrd_n;
  logic           oe_n, wrv_n, rdn_n;
  logic           mack_q, mack_n;

  assign rx_byte   = sh_q;
  assign addr_ack  = (st_q == ST_ADDR_ACK);
  assign ack_erase = addr_ack && (kind_q == K_ERASE);

  always_comb begin
    st_n    = st_q;
    kind_n  = kind_q;
    cnt_n   = cnt_q;
    sh_n    = sh_q;
    oe_n    = sda_oe_o;
    wrv_n   = 1'b0;
    wrd_n   = wr_data_o;
    rdn_n   = 1'b0;
    mack_n  = mack_q;
    arm_set = 1'b0;
    arm_clr = 1'b0;
    if (start_det) begin
      st_n    = ST_ADDR;
      cnt_n   = '0;
      oe_n    = 1'b0;
      arm_clr = 1'b1;
    end else if (stop_det) begin
      st_n = ST_IDLE;
      oe_n = 1'b0;
    end else begin
      case (st_q)
        ST_ADDR: begin
          if (scl_rise) begin
            sh_n  = {sh_q[DW-2:0], sda_s};
            cnt_n = cnt_q + 1'b1;
          end else if (scl_fall && (cnt_q == CW'(DW))) begin
            if (ack_ok) begin
              st_n    = ST_ADDR_ACK;
              oe_n    = 1'b1;
              arm_set = hit_erase;
              if (hit_erase)    kind_n = K_ERASE;
              else if (sh_q[0]) kind_n = K_RD;
              else              kind_n = K_WR;
            end else begin
              st_n    = ST_IDLE;
              arm_clr = 1'b1;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall) begin
            oe_n  = 1'b0;
            cnt_n = '0;
            case (kind_q)
              K_ERASE: st_n = ST_HOLD;
              K_RD: begin
                st_n  = ST_RD;
                sh_n  = rd_data_i;
                oe_n  = !rd_data_i[DW-1];
                rdn_n = 1'b1;
              end
              default: st_n = ST_WR;
            endcase
          end
        end
        ST_WR: begin
          if (scl_rise) begin
            sh_n  = {sh_q[DW-2:0], sda_s};
            cnt_n = cnt_q + 1'b1;
          end else if (scl_fall && (cnt_q == CW'(DW))) begin
            st_n  = ST_WR_ACK;
            wrv_n = 1'b1;
            wrd_n = sh_q;
            oe_n  = 1'b1;
          end
        end
        ST_WR_ACK: begin
          if (scl_fall) begin
            st_n  = ST_WR;
            oe_n  = 1'b0;
            cnt_n = '0;
          end
        end
        ST_RD: begin
          if (scl_fall) begin
            if (cnt_q == CW'(DW - 1)) begin
              st_n  = ST_RD_ACK;
              oe_n  = 1'b0;
              cnt_n = '0;
            end else begin
              sh_n  = {sh_q[DW-2:0], 1'b0};
              oe_n  = !sh_q[DW-2];
              cnt_n = cnt_q + 1'b1;
            end
          end
        end
        ST_RD_ACK: begin
          if (scl_rise) begin
            mack_n = !sda_s;
          end else if (scl_fall) begin
            if (mack_q) begin
              st_n  = ST_RD;
              sh_n  = rd_data_i;
              oe_n  = !rd_data_i[DW-1];
              rdn_n = 1'b1;
            end else begin
              st_n = ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      kind_q     <= K_WR;
      cnt_q      <= '0;
      sh_q       <= '0;
      sda_oe_o   <= 1'b0;
      wr_valid_o <= 1'b0;
      wr_data_o  <= '0;
      rd_next_o  <= 1'b0;
      mack_q     <= 1'b0;
    end else begin
      st_q       <= st_n;
      kind_q     <= kind_n;
      cnt_q      <= cnt_n;
      sh_q       <= sh_n;
      sda_oe_o   <= oe_n;
      wr_valid_o <= wrv_n;
      wr_data_o  <= wrd_n;
      rd_next_o  <= rdn_n;
      mack_q     <= mack_n;
    end
  end

  // R3: each received byte is strobed for a single clock
  p_wr_pulse_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o |=> !wr_valid_o);

  // R4: a fetch strobe is never stretched across two clocks
  p_rd_pulse_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_next_o |=> !rd_next_o);

endmodule

// File: rtl/i2c_ers_slave.sv
module i2c_ers_slave #(
  parameter int AW     = 7,
  parameter int EB     = 3,
  parameter int STAGES = 2,
  localparam int DW    = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe_o,
  input  logic [AW-1:0] dev_addr_i,
  input  logic          wp_i,
  output logic          erase_start_o,
  input  logic          erase_done_i,
  output logic          busy_o,
  output logic          wr_valid_o,
  output logic [DW-1:0] wr_data_o,
  output logic          rd_next_o,
  input  logic [DW-1:0] rd_data_i
);

  logic          sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic          ack_ok, hit_erase, arm_set, arm_clr;
  logic          addr_ack, ack_erase;
  logic [DW-1:0] rx_byte;

  i2c_ers_line_sync #(.STAGES(STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2c_ers_addr_match #(.AW(AW), .EB(EB), .DW(DW)) u_match (
    .rx_byte   (rx_byte),
    .dev_addr  (dev_addr_i),
    .wp        (wp_i),
    .busy      (busy_o),
    .hit_erase (hit_erase),
    .ack_ok    (ack_ok)
  );

  i2c_ers_bus_fsm #(.DW(DW)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .sda_s      (sda_s),
    .scl_rise   (scl_rise),
    .scl_fall   (scl_fall),
    .start_det  (start_det),
    .stop_det   (stop_det),
    .ack_ok     (ack_ok),
    .hit_erase  (hit_erase),
    .rd_data_i  (rd_data_i),
    .rx_byte    (rx_byte),
    .sda_oe_o   (sda_oe_o),
    .wr_valid_o (wr_valid_o),
    .wr_data_o  (wr_data_o),
    .rd_next_o  (rd_next_o),
    .arm_set    (arm_set),
    .arm_clr    (arm_clr),
    .addr_ack   (addr_ack),
    .ack_erase  (ack_erase)
  );

  i2c_ers_erase_ctrl u_erase (
    .clk           (clk),
    .rst_n         (rst_n),
    .arm_set       (arm_set),
    .arm_clr       (arm_clr),
    .stop_det      (stop_det),
    .erase_done_i  (erase_done_i),
    .erase_start_o (erase_start_o),
    .busy_o        (busy_o)
  );

  // R5: the device address must differ from the erase address
  p_cfg_distinct_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dev_addr_i[EB-1:0] != '1);

  // R10: no address acknowledge begins while an erase runs
  p_no_ack_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(addr_ack) |-> !busy_o);

  // R7: the erase address is only acknowledged with protect low
  p_wp_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_erase) |-> !$past(wp_i));

  // R8: an erase is launched only by a stop condition
  p_erase_on_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start_o |-> $past(stop_det));

  // R3: no write strobe while the memory is being erased
  p_no_write_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o |-> !busy_o);

endmodule

// File: tb/i2c_ers_slave_bench.sv
`timescale 1ns/1ps
module i2c_ers_slave_bench;

  localparam int Q = 8;
  localparam logic [6:0] DEV = 7'h52;
  localparam logic [7:0] A_WR  = 8'hA4;
  localparam logic [7:0] A_RD  = 8'hA5;
  localparam logic [7:0] A_EW  = 8'hAE;
  localparam logic [7:0] A_ER  = 8'hAF;
  localparam logic [7:0] A_BAD = 8'hC4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic       wp = 1'b0;
  logic       erase_done = 1'b0;
  logic       sda_line;
  logic       sda_oe, erase_start, busy, wr_valid, rd_next;
  logic [7:0] wr_data, rd_data;

  int checks = 0;
  int errors = 0;
  int erase_seen = 0;
  int rd_idx = 0;
  int rd_pulses = 0;
  bit erase_allowed = 1'b0;
  logic [7:0] exp_wr[$];

  always #2.5 clk = ~clk;

  assign sda_line = sda_m & ~sda_oe;

  function automatic logic [7:0] rd_val(int i);
    return 8'h9C ^ 8'(i * 37);
  endfunction

  assign rd_data = rd_val(rd_idx);

  i2c_ers_slave u_i2c_ers_slave (
    .clk           (clk),
    .rst_n         (rst_n),
    .scl_i         (scl_m),
    .sda_i         (sda_line),
    .sda_oe_o      (sda_oe),
    .dev_addr_i    (DEV),
    .wp_i          (wp),
    .erase_start_o (erase_start),
    .erase_done_i  (erase_done),
    .busy_o        (busy),
    .wr_valid_o    (wr_valid),
    .wr_data_o     (wr_data),
    .rd_next_o     (rd_next),
    .rd_data_i     (rd_data)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // reference model: queue of expected write bytes, read source index,
  // erase permission window; compared on every clock
  always @(negedge clk) begin
    if (rst_n) begin
      if (wr_valid) begin
        if (exp_wr.size() == 0) begin
          chk(1'b0, "R3", "unexpected write strobe", wr_data, 0);
        end else begin
          logic [7:0] e;
          e = exp_wr.pop_front();
          chk(wr_data == e, "R3", "written byte", wr_data, e);
        end
      end
      if (rd_next) begin
        rd_idx++;
        rd_pulses++;
      end
      if (erase_start) begin
        erase_seen++;
        chk(erase_allowed, "R8", "erase start outside stop window", 1, 0);
      end
    end
  end

  task automatic wq;
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start;
    sda_m = 1'b1; wq;
    scl_m = 1'b1; wq;
    sda_m = 1'b0; wq;
    scl_m = 1'b0; wq;
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; wq;
    scl_m = 1'b1; wq;
    sda_m = 1'b1; wq;
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq;
      scl_m = 1'b1; wq;
      scl_m = 1'b0; wq;
    end
    sda_m = 1'b1; wq;
    scl_m = 1'b1; wq;
    acked = (sda_line == 1'b0);
    scl_m = 1'b0; wq;
  endtask

  task automatic read_byte(input bit mack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq;
      scl_m = 1'b1; wq;
      b[i] = sda_line;
      scl_m = 1'b0;
    end
    wq;
    sda_m = mack ? 1'b0 : 1'b1; wq;
    scl_m = 1'b1; wq;
    scl_m = 1'b0; wq;
    sda_m = 1'b1;
  endtask

  task automatic finish_erase;
    erase_done = 1'b1;
    @(negedge clk);
    erase_done = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(negedge clk);
    chk(1'b0, "WDOG", "run did not complete", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    bit ack;
    logic [7:0] b;
    logic [7:0] e0, e1;
    int er0, rp0;

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // reset state
    chk(!sda_oe && !busy && !erase_start && !wr_valid && !rd_next,
        "R2", "reset outputs idle", {sda_oe, busy, erase_start, wr_valid}, 0);

    // R2 / R3: normal write of two bytes
    bus_start;
    send_byte(A_WR, ack);
    chk(ack, "R2", "own write address ack", ack, 1);
    exp_wr.push_back(8'hA5);
    send_byte(8'hA5, ack);
    chk(ack, "R3", "data byte 1 ack", ack, 1);
    exp_wr.push_back(8'h3C);
    send_byte(8'h3C, ack);
    chk(ack, "R3", "data byte 2 ack", ack, 1);
    bus_stop;
    chk(exp_wr.size() == 0, "R3", "all bytes delivered", exp_wr.size(), 0);

    // R4: read two bytes, ack then nack
    e0 = rd_val(rd_idx);
    e1 = rd_val(rd_idx + 1);
    rp0 = rd_pulses;
    bus_start;
    send_byte(A_RD, ack);
    chk(ack, "R2", "own read address ack", ack, 1);
    read_byte(1'b1, b);
    chk(b == e0, "R4", "read byte 1", b, e0);
    read_byte(1'b0, b);
    chk(b == e1, "R4", "read byte 2", b, e1);
    bus_stop;
    chk(rd_pulses - rp0 == 2, "R4", "fetch count after nack", rd_pulses - rp0, 2);

    // R11: unknown address ignored
    bus_start;
    send_byte(A_BAD, ack);
    chk(!ack, "R11", "unknown address nack", ack, 0);
    send_byte(8'h11, ack);
    chk(!ack, "R11", "byte after unknown address ignored", ack, 0);
    bus_stop;

    // R6: erase address with read direction
    er0 = erase_seen;
    bus_start;
    send_byte(A_ER, ack);
    chk(!ack, "R6", "erase address read direction nack", ack, 0);
    bus_stop;
    chk(erase_seen == er0 && !busy, "R6", "no erase on read direction", erase_seen - er0, 0);

    // R7: write protect blocks erase
    wp = 1'b1;
    bus_start;
    send_byte(A_EW, ack);
    chk(!ack, "R7", "erase address nack under protect", ack, 0);
    bus_stop;
    chk(erase_seen == er0 && !busy, "R7", "no erase under protect", erase_seen - er0, 0);
    wp = 1'b0;

    // R5 / R8: accepted erase, deferred to stop
    bus_start;
    send_byte(A_EW, ack);
    chk(ack, "R5", "erase address ack", ack, 1);
    send_byte(8'h00, ack);
    chk(!ack, "R5", "byte after erase address nack", ack, 0);
    chk(erase_seen == er0, "R8", "no erase before stop", erase_seen - er0, 0);
    erase_allowed = 1'b1;
    bus_stop;
    erase_allowed = 1'b0;
    chk(erase_seen == er0 + 1, "R8", "one erase after stop", erase_seen - er0, 1);
    chk(busy, "R10", "busy after erase start", busy, 1);

    // R10: polling while busy
    bus_start;
    send_byte(A_WR, ack);
    chk(!ack, "R10", "own address nack while busy", ack, 0);
    bus_stop;
    bus_start;
    send_byte(A_EW, ack);
    chk(!ack, "R10", "erase address nack while busy", ack, 0);
    bus_stop;
    chk(erase_seen == er0 + 1, "R10", "no second erase", erase_seen - er0, 1);
    finish_erase;
    chk(!busy, "R10", "busy clears after done", busy, 0);
    bus_start;
    send_byte(A_WR, ack);
    chk(ack, "R10", "own address ack after erase", ack, 1);
    bus_stop;

    // R9: repeated start cancels pending erase
    er0 = erase_seen;
    bus_start;
    send_byte(A_EW, ack);
    chk(ack, "R9", "erase address ack", ack, 1);
    bus_start;
    send_byte(A_WR, ack);
    chk(ack, "R9", "write address after repeated start", ack, 1);
    exp_wr.push_back(8'h77);
    send_byte(8'h77, ack);
    bus_stop;
    chk(erase_seen == er0 && !busy, "R9", "erase cancelled by repeated start", erase_seen - er0, 0);

    // R9: unknown address after repeated start cancels too
    bus_start;
    send_byte(A_EW, ack);
    bus_start;
    send_byte(A_BAD, ack);
    chk(!ack, "R9", "unknown address nack", ack, 0);
    bus_stop;
    chk(erase_seen == er0 && !busy, "R9", "erase cancelled by unknown address", erase_seen - er0, 0);

    // R1: repeated start mid-byte restarts decode
    e0 = rd_val(rd_idx);
    bus_start;
    send_byte(A_WR, ack);
    sda_m = 1'b1; wq; scl_m = 1'b1; wq; scl_m = 1'b0; wq;
    bus_start;
    send_byte(A_RD, ack);
    chk(ack, "R1", "read address after mid-byte start", ack, 1);
    read_byte(1'b0, b);
    chk(b == e0, "R1", "read after restart", b, e0);
    bus_stop;

    // R1: clocking without a start is ignored
    scl_m = 1'b0; wq;
    send_byte(A_WR, ack);
    chk(!ack, "R1", "address without start ignored", ack, 0);
    bus_stop;
    chk(exp_wr.size() == 0 && !sda_oe, "R1", "bus left idle", exp_wr.size(), 0);

    repeat (10) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule